// File: doc/BRIEF.md
# Read-Miss Bus Sequencer

This block turns one cache read miss into a complete transaction on a pipelined, split-transaction system bus. A requester offers a miss address with a valid/ready handshake. In the next clock the sequencer raises its bus request and stays in arbitration until the grant comes. It then spends one clock in resolution and drives the address for one clock. It steps through the decode and acknowledge phases and waits on the separate data bus for the line to come back.

The address path and the data path are kept apart. After the acknowledge phase the address bus plays no further part in this read, and the data bus is watched only inside a window. That window opens a fixed number of clocks after the address phase. The line arrives as consecutive wide beats. These beats are packed into a line register, and a one-clock done pulse tells the requester that the whole line is present. Only one miss is in flight at a time.

Top module: `rms_read_miss_seq`

## Requirements
- R1: The `phase` output walks idle(0) → arbitrate(1) → resolve(2) → address(3) → decode(4) → acknowledge(5) → data wait(6), one clock each from resolve through acknowledge, and returns to idle(0) in the clock after the last beat is taken.
- R2: A miss accepted on a clock edge puts the sequencer in arbitrate in the very next clock with `bus_req` high. `bus_req` stays high until a clock in which `bus_gnt` is seen, so with an immediate grant arbitrate plus resolve last exactly 2 clocks.
- R3: `addr_valid` is high for exactly one clock, the clock after resolve, and `addr_bus` then carries the accepted miss address. Outside that clock `addr_bus` is zero.
- R4: Data beats are taken only when `dbus_valid` is high in a clock at least 12 clocks after the address clock, and only while the line is still incomplete. Pulses earlier than that, and pulses after the line is complete, leave `line_data` unchanged.
- R5: A line of 1024 bits is filled by 4 beats of 256 bits in arrival order. The first beat goes to bits 255:0 and the fourth to bits 1023:768.
- R6: With an idle bus and data on time, `line_done` is high for exactly one clock, 16 clocks after the address clock, with the full line already on `line_data`. That is 18 clocks after `bus_req` first rises.
- R7: `miss_ready` is high only in idle. It falls in the clock after acceptance and rises again in the clock `line_done` is high. A `miss_valid` while `miss_ready` is low has no effect.
- R8: A synchronous active-high `rst` returns the sequencer to idle with `bus_req`, `addr_valid` and `line_done` low and `miss_ready` high. It also clears the beat and latency counts, so the next miss fills its line from beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| miss_valid | input | 1 | Requester offers a miss |
| miss_addr | input | 32 | Miss address |
| miss_ready | output | 1 | Sequencer can accept a miss |
| bus_req | output | 1 | Arbitration request |
| bus_gnt | input | 1 | Arbitration grant |
| addr_valid | output | 1 | Address phase strobe |
| addr_bus | output | 32 | Address driven in the address phase |
| phase | output | 3 | Current phase code |
| dbus_valid | input | 1 | Data bus beat present |
| dbus_data | input | 256 | Data bus beat |
| line_data | output | 1024 | Assembled cache line |
| line_done | output | 1 | One-clock pulse: line complete |

## Verification
Every miss is run with the grant held back for 0, 1, 2 and 3 clocks, using several addresses whose beats all differ. These runs show whether the arbitration wait shifts every later phase by the same amount, and whether the 18-clock idle-bus total holds. Each address is then run again with noise added: data-valid pulses before the capture window and after the line is complete, plus miss requests while busy. Only a design that really ignores these inputs survives the noisy runs. A reset in the middle of the beats, followed by a clean miss, shows that the beat count starts again at zero.

// File: rtl/rms_pkg.sv
package rms_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ARB  = 3'd1,
        PH_RES  = 3'd2,
        PH_ADDR = 3'd3,
        PH_DEC  = 3'd4,
        PH_ACK  = 3'd5,
        PH_DATA = 3'd6
    } phase_e;
endpackage

// File: rtl/rms_phase_ctl.sv
// Address-side phase sequencer with address-to-data latency count.
module rms_phase_ctl #(
    parameter int ADDR_W = 32,
    parameter int LAT    = 12,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              grant,
    input  logic              line_last,
    output rms_pkg::phase_e   ph,
    output logic              req,
    output logic              avalid,
    output logic [ADDR_W-1:0] aout,
    output logic              window
);
    import rms_pkg::*;

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  lat;
        logic [ADDR_W-1:0] addr;
    } ctl_t;

    ctl_t q, d;

    function automatic logic [CNT_W-1:0] lat_step(input logic [CNT_W-1:0] v);
        return (v == CNT_W'(LAT)) ? v : v + 1'b1;
    endfunction

    always_comb begin
        d = q;
        unique case (q.ph)
            PH_IDLE: begin
                d.lat = '0;
                if (start) begin
                    d.ph   = PH_ARB;
                    d.addr = start_addr;
                end
            end
            PH_ARB:  if (grant) d.ph = PH_RES;
            PH_RES:  begin d.ph = PH_ADDR; d.lat = '0; end
            PH_ADDR: begin d.ph = PH_DEC;  d.lat = lat_step(q.lat); end
            PH_DEC:  begin d.ph = PH_ACK;  d.lat = lat_step(q.lat); end
            PH_ACK:  begin d.ph = PH_DATA; d.lat = lat_step(q.lat); end
            PH_DATA: begin
                d.lat = lat_step(q.lat);
                if (line_last) d.ph = PH_IDLE;
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{ph: PH_IDLE, lat: '0, addr: '0};
        else     q <= d;
    end

    assign ph     = q.ph;
    assign req    = (q.ph == PH_ARB);
    assign avalid = (q.ph == PH_ADDR);
    assign aout   = avalid ? q.addr : '0;
    assign window = (q.ph == PH_DATA) && (q.lat == CNT_W'(LAT));
endmodule

// File: rtl/rms_line_fill.sv
// Beat counter and line assembly register.
module rms_line_fill #(
    parameter int DATA_W = 256,
    parameter int BEATS  = 4,
    parameter int BEAT_W = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    window,
    input  logic                    dv,
    input  logic [DATA_W-1:0]       din,
    output logic [BEATS*DATA_W-1:0] line,
    output logic                    last,
    output logic                    done
);
    typedef struct packed {
        logic [BEAT_W-1:0]       beat;
        logic [BEATS*DATA_W-1:0] line;
        logic                    done;
    } fill_t;

    fill_t q, d;
    logic  cap;

    assign cap  = window && dv;
    assign last = cap && (q.beat == BEAT_W'(BEATS - 1));

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (cap) begin
            d.line[int'(q.beat)*DATA_W +: DATA_W] = din;
            d.beat = last ? '0 : q.beat + 1'b1;
            d.done = last;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{beat: '0, line: '0, done: 1'b0};
        else     q <= d;
    end

    assign line = q.line;
    assign done = q.done;
endmodule

// File: rtl/rms_read_miss_seq.sv
// Read-miss sequencer for a split-transaction bus (top).
module rms_read_miss_seq #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 256,
    parameter int LINE_BYTES = 128,
    parameter int LAT        = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    miss_valid,
    input  logic [ADDR_W-1:0]       miss_addr,
    output logic                    miss_ready,
    output logic                    bus_req,
    input  logic                    bus_gnt,
    output logic                    addr_valid,
    output logic [ADDR_W-1:0]       addr_bus,
    output logic [2:0]              phase,
    input  logic                    dbus_valid,
    input  logic [DATA_W-1:0]       dbus_data,
    output logic [LINE_BYTES*8-1:0] line_data,
    output logic                    line_done
);
    import rms_pkg::*;

    localparam int LINE_W = LINE_BYTES * 8;
    localparam int BEATS  = LINE_W / DATA_W;
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int CNT_W  = $clog2(LAT + 1);

    phase_e ph;
    logic   window, last, accept;

    assign miss_ready = (ph == PH_IDLE);
    assign accept     = miss_valid && miss_ready;
    assign phase      = ph;

    rms_phase_ctl #(.ADDR_W(ADDR_W), .LAT(LAT), .CNT_W(CNT_W)) u_ctl (
        .clk(clk), .rst(rst), .start(accept), .start_addr(miss_addr),
        .grant(bus_gnt), .line_last(last), .ph(ph), .req(bus_req),
        .avalid(addr_valid), .aout(addr_bus), .window(window)
    );

    rms_line_fill #(.DATA_W(DATA_W), .BEATS(BEATS), .BEAT_W(BEAT_W)) u_fill (
        .clk(clk), .rst(rst), .window(window), .dv(dbus_valid),
        .din(dbus_data), .line(line_data), .last(last), .done(line_done)
    );
endmodule

// File: rtl/rms_checker.sv
module rms_checker #(
    parameter int ADDR_W = 32,
    parameter int LAT    = 12,
    parameter int BEATS  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              miss_valid,
    input logic [ADDR_W-1:0] miss_addr,
    input logic              miss_ready,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              addr_valid,
    input logic [ADDR_W-1:0] addr_bus,
    input logic [2:0]        phase,
    input logic              line_done
);
    logic [15:0]       since_addr;
    logic [ADDR_W-1:0] held_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_addr <= '0;
            held_addr  <= '0;
        end else begin
            if (addr_valid)              since_addr <= 16'd1;
            else if (since_addr != '1 && since_addr != '0) since_addr <= since_addr + 1'b1;
            if (miss_valid && miss_ready) held_addr <= miss_addr;
        end
    end

    a_r1_res_to_addr: assert property (@(posedge clk) disable iff (rst)
        phase == 3'd2 |=> phase == 3'd3);
    a_r1_addr_to_dec: assert property (@(posedge clk) disable iff (rst)
        phase == 3'd3 |=> phase == 3'd4);
    a_r1_dec_to_ack: assert property (@(posedge clk) disable iff (rst)
        phase == 3'd4 |=> phase == 3'd5);
    a_r2_hold_req: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_gnt |=> bus_req);
    a_r2_grant_res: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_gnt |=> phase == 3'd2 && !bus_req);
    a_r3_addr_value: assert property (@(posedge clk) disable iff (rst)
        addr_valid |-> addr_bus == held_addr);
    a_r3_addr_single: assert property (@(posedge clk) disable iff (rst)
        addr_valid |=> !addr_valid);
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        line_done |=> !line_done);
    a_r6_done_timing: assert property (@(posedge clk) disable iff (rst)
        line_done |-> since_addr >= 16'(LAT + BEATS));
    a_r7_ready_drop: assert property (@(posedge clk) disable iff (rst)
        miss_valid && miss_ready |=> !miss_ready && bus_req);
    a_r7_done_ready: assert property (@(posedge clk) disable iff (rst)
        line_done |-> miss_ready);
endmodule

bind rms_read_miss_seq rms_checker #(.ADDR_W(ADDR_W), .LAT(LAT), .BEATS(BEATS)) u_chk (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_ready(miss_ready), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .addr_valid(addr_valid), .addr_bus(addr_bus), .phase(phase),
    .line_done(line_done)
);

// File: tb/tb_rms_read_miss_seq.sv
module tb_rms_read_miss_seq;
    localparam int CLK_P = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          miss_valid = 1'b0;
    logic [31:0]   miss_addr = '0;
    logic          miss_ready;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic          addr_valid;
    logic [31:0]   addr_bus;
    logic [2:0]    phase;
    logic          dbus_valid = 1'b0;
    logic [255:0]  dbus_data = '0;
    logic [1023:0] line_data;
    logic          line_done;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    rms_read_miss_seq dut (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .miss_ready(miss_ready), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .addr_valid(addr_valid), .addr_bus(addr_bus), .phase(phase),
        .dbus_valid(dbus_valid), .dbus_data(dbus_data),
        .line_data(line_data), .line_done(line_done)
    );

    task automatic chk(input bit ok, input string req, input logic [1023:0] act,
                       input logic [1023:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [255:0] beat_val(input logic [31:0] a, input int b);
        logic [255:0] r;
        for (int i = 0; i < 8; i++)
            r[i*32 +: 32] = a ^ (32'(b + 1) << 24) ^ (32'(i) << 8) ^ 32'h005A_0000;
        return r;
    endfunction

    function automatic logic [1023:0] line_val(input logic [31:0] a);
        logic [1023:0] r;
        for (int b = 0; b < 4; b++) r[b*256 +: 256] = beat_val(a, b);
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // One miss: grant withheld gd clocks; noisy adds stray inputs; abort_at>0 resets there.
    task automatic run_miss(input logic [31:0] a, input int gd, input bit noisy,
                            input int abort_at);
        int A;
        int ex_ph;
        A = gd + 3;
        chk(miss_ready == 1'b1, "R7 ready in idle", 1024'(miss_ready), 1024'(1));
        miss_valid = 1'b1;
        miss_addr  = a;
        bus_gnt    = 1'b0;
        tick();
        for (int c = 1; c <= A + 17; c++) begin
            if (c == abort_at) begin
                rst = 1'b1;
                miss_valid = 1'b0; dbus_valid = 1'b0; bus_gnt = 1'b0;
                tick();
                rst = 1'b0;
                chk(phase == 3'd0, "R8 phase idle after reset", 1024'(phase), 1024'(0));
                chk(miss_ready && !bus_req && !addr_valid && !line_done,
                    "R8 outputs after reset",
                    1024'({miss_ready, bus_req, addr_valid, line_done}), 1024'(4'b1000));
                return;
            end
            miss_valid = noisy && (c == 4 || c == A + 13);
            miss_addr  = noisy ? ~a : a;
            bus_gnt    = (c >= gd + 1);
            dbus_valid = 1'b0;
            dbus_data  = ~beat_val(a, 7);
            if (c >= A + 12 && c <= A + 15) begin
                dbus_valid = 1'b1;
                dbus_data  = beat_val(a, c - A - 12);
            end else if (noisy && (c == A + 5 || c == A + 11 || c == A + 16)) begin
                dbus_valid = 1'b1;
            end
            // outputs in this clock depend on state only
            if (c <= gd + 1)       ex_ph = 1;
            else if (c == gd + 2)  ex_ph = 2;
            else if (c == A)       ex_ph = 3;
            else if (c == A + 1)   ex_ph = 4;
            else if (c == A + 2)   ex_ph = 5;
            else if (c <= A + 15)  ex_ph = 6;
            else                   ex_ph = 0;
            chk(phase == 3'(ex_ph), "R1 phase sequence", 1024'(phase), 1024'(ex_ph));
            chk(bus_req == (c <= gd + 1), "R2 bus_req", 1024'(bus_req), 1024'(c <= gd + 1));
            chk(addr_valid == (c == A), "R3 addr_valid", 1024'(addr_valid), 1024'(c == A));
            chk(addr_bus == ((c == A) ? a : 32'h0), "R3 addr_bus", 1024'(addr_bus),
                1024'((c == A) ? a : 32'h0));
            chk(miss_ready == (c >= A + 16), "R7 ready low while busy",
                1024'(miss_ready), 1024'(c >= A + 16));
            chk(line_done == (c == A + 16), "R6 done pulse timing",
                1024'(line_done), 1024'(c == A + 16));
            if (c == A + 16)
                chk(line_data == line_val(a), "R5 line assembly order", line_data, line_val(a));
            if (c == A + 17)
                chk(line_data == line_val(a), "R4 late pulse ignored", line_data, line_val(a));
            if (c == A + 16 && gd == 0)
                chk(A + 15 - 1 + 1 == 18, "R6 18 clocks idle bus", 1024'(A + 15), 1024'(18));
            tick();
        end
        miss_valid = 1'b0;
        dbus_valid = 1'b0;
        bus_gnt    = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] addrs [4];
        addrs[0] = 32'h0000_0080;
        addrs[1] = 32'hDEAD_BE00;
        addrs[2] = 32'h1234_5680;
        addrs[3] = 32'hFFFF_FF80;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        chk(phase == 3'd0, "R8 reset phase", 1024'(phase), 1024'(0));
        chk(miss_ready && !bus_req && !addr_valid && !line_done, "R8 reset outputs",
            1024'({miss_ready, bus_req, addr_valid, line_done}), 1024'(4'b1000));
        chk(line_data == '0, "R8 reset line", line_data, '0);
        for (int n = 0; n < 2; n++)
            for (int g = 0; g < 4; g++)
                for (int k = 0; k < 4; k++) begin
                    run_miss(addrs[k], g, n[0], 0);
                    tick();
                end
        // reset during the beats (two taken), then a clean miss must start at beat 0
        run_miss(32'hA5A5_0000, 0, 1'b0, 3 + 14);
        run_miss(32'h0F0F_0F00, 1, 1'b0, 0);
        tick();
        // reset during arbitration
        run_miss(32'h3333_3300, 3, 1'b0, 2);
        run_miss(32'h4444_4400, 0, 1'b1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule